// File: doc/BRIEF.md
# Shift Unit with Carry-Out

A purely combinational shifter for the execute stage of a 32-bit processor with 16-bit instructions. It takes one operand and applies a logical left shift, a logical right shift, an arithmetic right shift or a right rotate. It returns the shifted value together with fresh negative (N), zero (Z) and carry (C) flags. The overflow flag (V) passes straight through.

The shift distance comes from one of two sources. The first is a 5-bit field taken from the instruction. The second is a register operand, of which only the low byte counts. Some amounts have special meanings:
- An immediate field of zero means a shift by the full word width for the right shifts.
- Register distances at and beyond the word width follow their own carry rules.

A distance of zero keeps the incoming carry. Register writeback and instruction fetch belong to the surrounding pipeline.

There is no stored state, so the style's state machine reduces to the decode path. The path runs as follows:
1. The amount decoder picks the effective distance.
2. A funnel shifter of log2(width) stages forms the value.
3. A range selector applies the zero, exact-width and over-width cases.
4. A flag stage forms N and Z.

Top module: `shift_flag_unit`

## Requirements
- R1: The operation select encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For a distance k with 1 <= k <= 31, the result is the shifted operand and C is the last bit shifted out. For a left shift that is operand bit 32-k; for a right shift it is operand bit k-1.
- R2: With the immediate source selected (use_reg_i = 0) and a logical-left field of 0, the result equals the operand and C equals c_i.
- R3: With the immediate source, a logical-right field of 0 means a shift by 32: the result is 0 and C is operand bit 31.
- R4: With the immediate source, an arithmetic-right field of 0 means a shift by 32: every result bit equals operand bit 31, and C is operand bit 31.
- R5: With the register source (use_reg_i = 1), only bits 7:0 of amt_reg_i form the distance; bits 31:8 have no effect. A register distance of 0 leaves the result equal to the operand and C equal to c_i, for every operation.
- R6: A register distance of exactly 32 gives result 0 for both logical shifts. C is operand bit 0 for the left shift and operand bit 31 for the right shift.
- R7: A register distance of 33 to 255 gives result 0 and C = 0 for both logical shifts. An arithmetic-right register distance of 32 or more gives the sign fill, and C is operand bit 31.
- R8: Rotate right uses the distance modulo 32. For a nonzero remainder, C equals result bit 31. A nonzero distance that is a multiple of 32 leaves the operand unchanged and sets C to operand bit 31. An immediate rotate field of 0 leaves the operand and the carry unchanged.
- R9: N equals result bit 31, and Z is 1 exactly when the result is all zeros.
- R10: v_o always equals v_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to be shifted |
| amt_reg_i | input | 32 | Register operand holding the distance (low 8 bits used) |
| amt_imm_i | input | 5 | Distance field from the instruction |
| use_reg_i | input | 1 | 1 = take distance from amt_reg_i, 0 = from amt_imm_i |
| op_i | input | 2 | Operation select (see R1) |
| c_i | input | 1 | Incoming carry flag |
| v_i | input | 1 | Incoming overflow flag |
| result_o | output | 32 | Shifted value |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag (passed through) |

## Verification
The bench builds the unit with its default parameters:
- a 32-bit data path;
- a 5-bit immediate field;
- an 8-bit effective register distance.

With these values every register distance from 0 to 255 can be reached from the bench. This covers the exact-width case, the over-width cases and the rotate multiples of 32. Junk placed in bits 31:8 of the register operand shows directly whether those bits are ignored. The reference model works on 64-bit integers and covers every operation with both amount sources. It is checked against directed corner vectors and several hundred pseudo-random vectors.

// File: rtl/shift_flag_pkg.sv
package shift_flag_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_op_e;

endpackage

// File: rtl/shift_amount_decode.sv
module shift_amount_decode
    import shift_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] amt_reg_i,
    input  logic [IMM_W-1:0]  amt_imm_i,
    input  logic              use_reg_i,
    input  shift_op_e         op_i,
    output logic [AMT_W-1:0]  amt_o
);

    // A zero immediate field on a right shift stands for a full-width shift.
    localparam logic [AMT_W-1:0] FULL_W = AMT_W'(DATA_W);

    logic [AMT_W-1:0] imm_amt;
    logic             unused_amt_hi;

    assign unused_amt_hi = ^amt_reg_i[DATA_W-1:AMT_W];

    always_comb begin
        imm_amt = AMT_W'(amt_imm_i);
        unique case (op_i)
            SH_LSR, SH_ASR: if (amt_imm_i == '0) imm_amt = FULL_W;
            default:        imm_amt = AMT_W'(amt_imm_i);
        endcase
        amt_o = use_reg_i ? amt_reg_i[AMT_W-1:0] : imm_amt;
    end

endmodule

// File: rtl/shift_funnel.sv
module shift_funnel #(
    parameter int DATA_W = 32,
    localparam int STG   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] hi_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [STG-1:0]    sh_i,
    output logic [DATA_W-1:0] dout_o
);

    logic [2*DATA_W-1:0] stage [0:STG];
    logic                unused_top;

    assign stage[0] = {hi_i, lo_i};

    // One conditional power-of-two step per distance bit.
    for (genvar k = 0; k < STG; k++) begin : g_stage
        assign stage[k+1] = sh_i[k] ? (stage[k] >> (1 << k)) : stage[k];
    end

    assign dout_o     = stage[STG][DATA_W-1:0];
    assign unused_top = ^stage[STG][2*DATA_W-1:DATA_W];

endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int STG   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  shift_op_e         op_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o
);

    localparam logic [AMT_W-1:0] FULL_W = AMT_W'(DATA_W);

    logic [DATA_W-1:0] a_rev, hi_in, lo_in, fun_out, fun_rev, shifted, fill;
    logic [STG-1:0]    s, s_m1;
    logic              amt_zero, amt_big, amt_exact, out_bit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign a_rev[i]   = a_i[DATA_W-1-i];
        assign fun_rev[i] = fun_out[DATA_W-1-i];
    end

    assign s         = amt_i[STG-1:0];
    assign s_m1      = s - STG'(1);
    assign amt_zero  = (amt_i == '0);
    assign amt_big   = (amt_i >= FULL_W);
    assign amt_exact = (amt_i == FULL_W);
    assign fill      = {DATA_W{a_i[DATA_W-1]}};

    // Funnel source: the left shift runs through the right funnel on reversed bits.
    always_comb begin
        unique case (op_i)
            SH_LSL: begin hi_in = '0;   lo_in = a_rev; end
            SH_LSR: begin hi_in = '0;   lo_in = a_i;   end
            SH_ASR: begin hi_in = fill; lo_in = a_i;   end
            SH_ROR: begin hi_in = a_i;  lo_in = a_i;   end
        endcase
    end

    shift_funnel #(.DATA_W(DATA_W)) u_funnel (
        .hi_i   (hi_in),
        .lo_i   (lo_in),
        .sh_i   (s),
        .dout_o (fun_out)
    );

    assign shifted = (op_i == SH_LSL) ? fun_rev : fun_out;
    assign out_bit = lo_in[s_m1];

    // Range selection: zero, in-range, exact width, beyond width.
    always_comb begin
        res_o = shifted;
        c_o   = out_bit;
        if (amt_zero) begin
            res_o = a_i;
            c_o   = c_i;
        end else if (op_i == SH_ROR) begin
            if (s == '0) begin
                res_o = a_i;
                c_o   = a_i[DATA_W-1];
            end
        end else if (amt_big) begin
            unique case (op_i)
                SH_LSL: begin
                    res_o = '0;
                    c_o   = amt_exact & a_i[0];
                end
                SH_LSR: begin
                    res_o = '0;
                    c_o   = amt_exact & a_i[DATA_W-1];
                end
                default: begin
                    res_o = fill;
                    c_o   = a_i[DATA_W-1];
                end
            endcase
        end
    end

endmodule

// File: rtl/shift_flag_gen.sv
module shift_flag_gen #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res_i,
    output logic              n_o,
    output logic              z_o
);

    assign n_o = res_i[DATA_W-1];
    assign z_o = ~|res_i;

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
    import shift_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] amt_reg_i,
    input  logic [IMM_W-1:0]  amt_imm_i,
    input  logic              use_reg_i,
    input  logic [1:0]        op_i,
    input  logic              c_i,
    input  logic              v_i,
    output logic [DATA_W-1:0] result_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o,
    output logic              v_o
);

    shift_op_e        op;
    logic [AMT_W-1:0] amt;

    assign op = shift_op_e'(op_i);

    shift_amount_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_dec (
        .amt_reg_i (amt_reg_i),
        .amt_imm_i (amt_imm_i),
        .use_reg_i (use_reg_i),
        .op_i      (op),
        .amt_o     (amt)
    );

    shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .a_i   (operand_i),
        .amt_i (amt),
        .op_i  (op),
        .c_i   (c_i),
        .res_o (result_o),
        .c_o   (c_o)
    );

    shift_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .res_i (result_o),
        .n_o   (n_o),
        .z_o   (z_o)
    );

    assign v_o = v_i;

endmodule

// File: rtl/shift_flag_unit_chk.sv
module shift_flag_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input logic [DATA_W-1:0] operand_i,
    input logic [DATA_W-1:0] amt_reg_i,
    input logic [IMM_W-1:0]  amt_imm_i,
    input logic              use_reg_i,
    input logic [1:0]        op_i,
    input logic              c_i,
    input logic              v_i,
    input logic [DATA_W-1:0] result_o,
    input logic              n_o,
    input logic              z_o,
    input logic              c_o,
    input logic              v_o
);

    logic known;
    assign known = !$isunknown({operand_i, amt_reg_i, amt_imm_i, use_reg_i, op_i, c_i, v_i});

    always_comb begin
        if (known) begin
            p_neg_flag_r9: assert (n_o == result_o[DATA_W-1])
                else $error("N flag mismatch");
            p_zero_flag_r9: assert (z_o == (result_o == '0))
                else $error("Z flag mismatch");
            p_v_pass_r10: assert (v_o == v_i)
                else $error("V not passed through");
            if (!use_reg_i && op_i == 2'd0 && amt_imm_i == '0) begin
                p_lsl_imm_zero_r2: assert (result_o == operand_i && c_o == c_i)
                    else $error("LSL #0 altered value or carry");
            end
            if (!use_reg_i && op_i == 2'd1 && amt_imm_i == '0) begin
                p_lsr_imm_full_r3: assert (result_o == '0 && c_o == operand_i[DATA_W-1])
                    else $error("LSR #32 wrong");
            end
            if (!use_reg_i && op_i == 2'd2 && amt_imm_i == '0) begin
                p_asr_imm_full_r4: assert (result_o == {DATA_W{operand_i[DATA_W-1]}}
                                           && c_o == operand_i[DATA_W-1])
                    else $error("ASR #32 wrong");
            end
            if (use_reg_i && amt_reg_i[7:0] == 8'd0) begin
                p_reg_zero_r5: assert (result_o == operand_i && c_o == c_i)
                    else $error("register distance 0 altered value or carry");
            end
            if (use_reg_i && op_i[1] == 1'b0 && amt_reg_i[7:0] > 8'd32) begin
                p_logic_over_r7: assert (result_o == '0 && c_o == 1'b0)
                    else $error("logical over-width shift wrong");
            end
            if (op_i == 2'd3 && result_o != operand_i) begin
                p_ror_carry_r8: assert (c_o == result_o[DATA_W-1])
                    else $error("rotate carry not result msb");
            end
        end
    end

endmodule

bind shift_flag_unit shift_flag_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .operand_i (operand_i),
    .amt_reg_i (amt_reg_i),
    .amt_imm_i (amt_imm_i),
    .use_reg_i (use_reg_i),
    .op_i      (op_i),
    .c_i       (c_i),
    .v_i       (v_i),
    .result_o  (result_o),
    .n_o       (n_o),
    .z_o       (z_o),
    .c_o       (c_o),
    .v_o       (v_o)
);

// File: tb/tb_shift_flag_unit.sv
module tb_shift_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand_i = '0;
    logic [31:0] amt_reg_i = '0;
    logic [4:0]  amt_imm_i = '0;
    logic        use_reg_i = 1'b0;
    logic [1:0]  op_i = '0;
    logic        c_i = 1'b0;
    logic        v_i = 1'b0;
    logic [31:0] result_o;
    logic        n_o, z_o, c_o, v_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    shift_flag_unit dut (
        .operand_i (operand_i),
        .amt_reg_i (amt_reg_i),
        .amt_imm_i (amt_imm_i),
        .use_reg_i (use_reg_i),
        .op_i      (op_i),
        .c_i       (c_i),
        .v_i       (v_i),
        .result_o  (result_o),
        .n_o       (n_o),
        .z_o       (z_o),
        .c_o       (c_o),
        .v_o       (v_o)
    );

    // Behavioural reference: returns {v, c, z, n, result}.
    function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] ra,
                                          input logic [4:0] imm, input logic ureg,
                                          input logic [1:0] op, input logic ci,
                                          input logic vi);
        int          k;
        logic [63:0] w;
        logic [31:0] r;
        logic        c;
        if (ureg) k = int'(ra[7:0]);
        else if (imm == 0 && (op == 2'd1 || op == 2'd2)) k = 32;
        else k = int'(imm);
        r = a;
        c = ci;
        if (k != 0) begin
            case (op)
                2'd0: begin
                    if (k > 32) begin r = 0; c = 0; end
                    else begin w = {32'b0, a} << k; r = w[31:0]; c = w[32]; end
                end
                2'd1: begin
                    if (k > 32) begin r = 0; c = 0; end
                    else begin w = {a, 32'b0} >> k; r = w[63:32]; c = w[31]; end
                end
                2'd2: begin
                    if (k >= 32) begin r = {32{a[31]}}; c = a[31]; end
                    else begin r = 32'($signed(a) >>> k); c = a[k-1]; end
                end
                default: begin
                    if (k % 32 == 0) begin r = a; c = a[31]; end
                    else begin w = {a, a} >> (k % 32); r = w[31:0]; c = r[31]; end
                end
            endcase
        end
        return {vi, c, (r == 0), r[31], r};
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] ra, input logic [4:0] imm,
                         input logic ureg, input logic [1:0] op, input logic ci,
                         input logic vi, input string tag);
        logic [35:0] exp_v, act_v;
        @(negedge clk);
        operand_i = a; amt_reg_i = ra; amt_imm_i = imm;
        use_reg_i = ureg; op_i = op; c_i = ci; v_i = vi;
        @(posedge clk);
        #1;
        exp_v = model(a, ra, imm, ureg, op, ci, vi);
        act_v = {v_o, c_o, z_o, n_o, result_o};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: op=%0d reg=%0b a=%h ra=%h imm=%0d actual vczn/res=%h expected=%h",
                     tag, op, ureg, a, ra, imm, act_v, exp_v);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: all-zero inputs give zero result with Z set (R9).
        apply(32'h0, 32'h0, 5'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R9");
        // R1: in-range shifts, each operation.
        apply(32'h8000_0001, 0, 5'd1, 0, 2'd0, 0, 0, "R1");
        apply(32'h4000_0000, 0, 5'd2, 0, 2'd0, 0, 0, "R1");
        apply(32'h0000_0003, 0, 5'd1, 0, 2'd1, 0, 0, "R1");
        apply(32'h8000_0010, 0, 5'd5, 0, 2'd2, 0, 0, "R1");
        apply(32'h1234_5678, 0, 5'd31, 0, 2'd1, 1, 0, "R1");
        // R2: LSL immediate zero keeps carry.
        apply(32'hDEAD_BEEF, 0, 5'd0, 0, 2'd0, 1, 0, "R2");
        apply(32'hDEAD_BEEF, 0, 5'd0, 0, 2'd0, 0, 1, "R2");
        // R3 / R4: zero field means 32 for right shifts.
        apply(32'h8000_0000, 0, 5'd0, 0, 2'd1, 0, 0, "R3");
        apply(32'h7FFF_FFFF, 0, 5'd0, 0, 2'd1, 1, 0, "R3");
        apply(32'h8000_1234, 0, 5'd0, 0, 2'd2, 0, 0, "R4");
        apply(32'h7000_1234, 0, 5'd0, 0, 2'd2, 1, 0, "R4");
        // R5: only low byte of the register counts; zero distance keeps carry.
        apply(32'hCAFE_F00D, 32'hFFFF_FF00, 5'd7, 1, 2'd0, 1, 0, "R5");
        apply(32'hCAFE_F00D, 32'hABCD_1200, 5'd3, 1, 2'd3, 0, 0, "R5");
        apply(32'hCAFE_F00D, 32'h5A5A_5A04, 5'd0, 1, 2'd1, 0, 0, "R5");
        // R6: exact width.
        apply(32'h0000_0001, 32'd32, 5'd0, 1, 2'd0, 0, 0, "R6");
        apply(32'h8000_0000, 32'd32, 5'd0, 1, 2'd1, 0, 0, "R6");
        // R7: beyond width.
        apply(32'hFFFF_FFFF, 32'd33, 5'd0, 1, 2'd0, 1, 0, "R7");
        apply(32'hFFFF_FFFF, 32'd255, 5'd0, 1, 2'd1, 1, 0, "R7");
        apply(32'h8000_0000, 32'd200, 5'd0, 1, 2'd2, 0, 0, "R7");
        apply(32'h4000_0000, 32'd32, 5'd0, 1, 2'd2, 1, 0, "R7");
        // R8: rotate modulo 32.
        apply(32'h0000_0001, 32'd1, 5'd0, 1, 2'd3, 0, 0, "R8");
        apply(32'h8765_4321, 32'd64, 5'd0, 1, 2'd3, 0, 0, "R8");
        apply(32'h0765_4321, 32'd36, 5'd0, 1, 2'd3, 1, 0, "R8");
        apply(32'h1234_5678, 0, 5'd0, 0, 2'd3, 1, 0, "R8");
        apply(32'h1234_5678, 0, 5'd8, 0, 2'd3, 0, 0, "R8");
        // R10: V passes through.
        apply(32'h0F0F_0F0F, 0, 5'd4, 0, 2'd1, 0, 1, "R10");
        // Mixed pseudo-random patterns.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra;
            int sel;
            sel = int'($urandom_range(0, 3));
            ra  = $urandom;
            if (sel == 0) ra[7:0] = 8'($urandom_range(30, 34));
            else if (sel == 1) ra[7:0] = 8'($urandom_range(0, 2));
            apply($urandom, ra, 5'($urandom), 1'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom), "R1");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule